// File: doc/BRIEF.md
# Timer Host Register Interface

This block is the processor-facing side of a three-channel, 16-bit interval timer. It has an 8-bit parallel bus with active-low chip select, read and write strobes and a 2-bit address. Three addresses reach the channels and the fourth reaches a write-only command register. Through the command register software programs each channel's access format, operating mode and count radix. It can also freeze a channel's count or status into a snapshot register, either one channel at a time or for several channels in a single command. Count bytes written to a channel address build up that channel's 16-bit initial-count register. Reads of a channel address return status, frozen count or live count, one byte per read.

The counting engines sit outside this block. For each channel an engine supplies the live count, its output level and a strobe that marks the moment it copies the initial-count register into its down-counter. In return it receives the initial count, the 6-bit programmed mode, a pulse when a command word reprograms the channel, and a pulse when a complete count has been written. All bus strobes are sampled in the system clock domain. A transfer takes effect on the clock edge that sees the strobe return high.

Top module: `tmr_host_if`

## Requirements
- R1: Address 0, 1 and 2 select channels 0, 1 and 2, and address 3 selects the command register. A read or write takes effect only on the clock edge at which its strobe is seen rising while chip select was low at the previous edge. With chip select high, nothing changes.
- R2: For a command byte with bits 7:6 not equal to 3 and bits 5:4 not zero, bits 7:6 name the channel. Bits 5:4 give the access format (1 = low byte only, 2 = high byte only, 3 = low byte then high byte), bits 3:1 give the mode and bit 0 selects BCD. The channel's `ch_mode` output becomes bits 5:0 of the command byte, and `ch_cw_wr` pulses for one cycle.
- R3: A command word clears the channel's 16-bit initial count to zero. A one-byte format therefore leaves the other byte at zero.
- R4: In format 3 the first data byte fills bits 7:0 and the second fills bits 15:8. `ch_cr_wr` pulses once per complete count: after every byte in formats 1 and 2, and only after the second byte in format 3.
- R5: A command byte with bits 5:4 = 0 freezes the selected channel's count. The frozen value is returned until the format's full number of bytes has been read, or until the channel is reprogrammed. After that, reads return the live count.
- R6: A count freeze or a status freeze sent to a channel whose snapshot of that kind is still unread is ignored. The first snapshot is returned.
- R7: A command byte with bits 7:6 = 3 is a read-back. Bits 3, 2 and 1 select channels 2, 1 and 0. Bit 5 = 0 freezes the count of each selected channel and bit 4 = 0 freezes its status.
- R8: A status byte is {output level, null-count flag, mode bits 5:0}.
- R9: When a channel holds both a status and a count snapshot, the first read returns the status whichever was taken first. The next one or two reads return the frozen count, and later reads return the live count.
- R10: `ch_null` is set by a command word to the channel and by a completed count write. It is cleared by `ch_load` in a cycle with neither of those.
- R11: Each channel has its own read byte pointer and write byte pointer, so format-3 reads and writes may interleave. A command word returns both pointers to the low byte.
- R12: `bus_dout` is 0x00 except while a channel read is in progress. A read of address 3 returns 0x00 and changes no state.
- R13: After reset every channel has initial count 0, mode 0x30, null-count flag 0 and no snapshots held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 2 | Channel or command register select |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Registered read data |
| ch_count | input | 3x16 | Live count of each channel's engine |
| ch_out | input | 3 | Output level of each engine |
| ch_load | input | 3 | Engine copied the initial count into its counter |
| ch_cr | output | 3x16 | Initial count per channel |
| ch_mode | output | 3x6 | Programmed format, mode and radix per channel |
| ch_null | output | 3 | Null-count flag per channel |
| ch_cr_wr | output | 3 | One-cycle pulse: complete count written |
| ch_cw_wr | output | 3 | One-cycle pulse: channel reprogrammed |

## Verification
The assertions check, on every cycle, that a strobe seen while chip select was high does nothing. They also check that a command word leaves the count cleared and the null flag set, that a held count snapshot stays unchanged until it is read (including against repeated freeze commands), that a read serving a status snapshot leaves the count pointer and count snapshot alone, and that the data output is idle outside reads. The bench scenarios are needed for the byte steering of every format, for status-before-count ordering in both latch orders, for interleaved reads and writes, and for multi-channel read-back. These depend on sequences of bus transfers and on values supplied by the engines.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_W  = 6;

  typedef enum logic [1:0] {
    FMT_FREEZE = 2'b00,
    FMT_LO     = 2'b01,
    FMT_HI     = 2'b10,
    FMT_WORD   = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [1:0] fmt;
    logic [2:0] mode;
    logic       bcd;
  } ctl_t;

  localparam logic [CTL_W-1:0] CTL_RESET = 6'h30;
endpackage

// File: rtl/tmr_strobe_sync.sv
module tmr_strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_done,
  output logic wr_done
);
  logic cs_q, rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  // a transfer completes when the strobe returns high while selected
  assign rd_done = rd_n & ~rd_q & ~cs_q;
  assign wr_done = wr_n & ~wr_q & ~cs_q;

  // R1: no transfer completes when chip select was high at the previous edge
  assert_cs_gates_R1: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> (!rd_done && !wr_done));
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_wr,
  input  logic [CTL_W-1:0]  cw_bits,
  input  logic              cnt_wr,
  input  logic [DW-1:0]     wr_data,
  input  logic              lat_cnt,
  input  logic              lat_st,
  input  logic              rd_done,
  input  logic [2*DW-1:0]   live_cnt,
  input  logic              out_lvl,
  input  logic              load,
  output logic [DW-1:0]     rd_byte,
  output logic [2*DW-1:0]   cr,
  output logic [CTL_W-1:0]  mode,
  output logic              null_cnt,
  output logic              cr_wr
);
  localparam int CW = 2 * DW;

  ctl_t          ctl;
  fmt_e          fmt;
  logic          wr_hi, rd_hi;
  logic [CW-1:0] ol;
  logic          ol_held;
  logic [DW-1:0] st;
  logic          st_held;
  logic [CW-1:0] rd_val;

  assign fmt  = fmt_e'(ctl.fmt);
  assign mode = ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= ctl_t'(CTL_RESET);
      cr       <= '0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      ol       <= '0;
      ol_held  <= 1'b0;
      st       <= '0;
      st_held  <= 1'b0;
      null_cnt <= 1'b0;
      cr_wr    <= 1'b0;
    end else begin
      cr_wr <= 1'b0;
      if (cw_wr) begin
        ctl      <= ctl_t'(cw_bits);
        cr       <= '0;
        wr_hi    <= 1'b0;
        rd_hi    <= 1'b0;
        ol_held  <= 1'b0;
        st_held  <= 1'b0;
        null_cnt <= 1'b1;
      end else begin
        if (load) null_cnt <= 1'b0;
        if (cnt_wr) begin
          unique case (fmt)
            FMT_LO: begin
              cr[DW-1:0] <= wr_data;
              null_cnt   <= 1'b1;
              cr_wr      <= 1'b1;
            end
            FMT_HI: begin
              cr[CW-1:DW] <= wr_data;
              null_cnt    <= 1'b1;
              cr_wr       <= 1'b1;
            end
            default: begin
              if (!wr_hi) begin
                cr[DW-1:0] <= wr_data;
                wr_hi      <= 1'b1;
              end else begin
                cr[CW-1:DW] <= wr_data;
                wr_hi       <= 1'b0;
                null_cnt    <= 1'b1;
                cr_wr       <= 1'b1;
              end
            end
          endcase
        end
        if (lat_cnt && !ol_held) begin
          ol      <= live_cnt;
          ol_held <= 1'b1;
        end
        if (lat_st && !st_held) begin
          st      <= {out_lvl, null_cnt, ctl};
          st_held <= 1'b1;
        end
        if (rd_done) begin
          if (st_held) begin
            st_held <= 1'b0;
          end else if (fmt == FMT_WORD && !rd_hi) begin
            rd_hi <= 1'b1;
          end else begin
            rd_hi   <= 1'b0;
            ol_held <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    rd_val = ol_held ? ol : live_cnt;
    if (st_held) begin
      rd_byte = st;
    end else begin
      unique case (fmt)
        FMT_HI:   rd_byte = rd_val[CW-1:DW];
        FMT_WORD: rd_byte = rd_hi ? rd_val[CW-1:DW] : rd_val[DW-1:0];
        default:  rd_byte = rd_val[DW-1:0];
      endcase
    end
  end

  // R3 / R10: reprogramming clears the count and raises null count
  assert_cw_clears_R3: assert property (@(posedge clk) disable iff (rst)
    cw_wr |=> (cr == '0) && null_cnt && !ol_held && !st_held);

  // R5: a held count snapshot survives until read or reprogrammed
  assert_snapshot_held_R5: assert property (@(posedge clk) disable iff (rst)
    (ol_held && !rd_done && !cw_wr) |=> (ol_held && $stable(ol)));

  // R6: a repeated freeze does not overwrite the held snapshot
  assert_repeat_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (ol_held && lat_cnt && !rd_done && !cw_wr) |=> $stable(ol));

  // R9: a read served from the status snapshot leaves the count path alone
  assert_status_first_R9: assert property (@(posedge clk) disable iff (rst)
    (st_held && rd_done && !cw_wr) |=> ($stable(ol_held) && $stable(rd_hi)));

  // R10: a transfer into the engine clears null count when nothing sets it
  assert_null_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (load && !cw_wr && !cnt_wr) |=> !null_cnt);
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NCH = 3,   // at most 3: the fourth address is the command register
  parameter int DW  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_cs_n,
  input  logic                          bus_rd_n,
  input  logic                          bus_wr_n,
  input  logic [1:0]                    bus_addr,
  input  logic [DW-1:0]                 bus_din,
  output logic [DW-1:0]                 bus_dout,
  input  logic [NCH-1:0][2*DW-1:0]      ch_count,
  input  logic [NCH-1:0]                ch_out,
  input  logic [NCH-1:0]                ch_load,
  output logic [NCH-1:0][2*DW-1:0]      ch_cr,
  output logic [NCH-1:0][CTL_W-1:0]     ch_mode,
  output logic [NCH-1:0]                ch_null,
  output logic [NCH-1:0]                ch_cr_wr,
  output logic [NCH-1:0]                ch_cw_wr
);
  localparam logic [1:0] CMD_ADDR = 2'b11;
  localparam logic [1:0] RB_SEL   = 2'b11;

  logic                   rd_done, wr_done;
  logic                   cmd_wr, is_rb;
  logic [NCH-1:0]         cw_vec, lat_cnt, lat_st, cnt_wr, rd_vec;
  logic [NCH-1:0][DW-1:0] rd_bytes;
  logic [DW-1:0]          rd_sel;
  logic                   rd_hit;

  tmr_strobe_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (bus_cs_n),
    .rd_n    (bus_rd_n),
    .wr_n    (bus_wr_n),
    .rd_done (rd_done),
    .wr_done (wr_done)
  );

  assign cmd_wr = wr_done && (bus_addr == CMD_ADDR);
  assign is_rb  = (bus_din[7:6] == RB_SEL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic named, freeze_cmd, rb_pick;
    assign named      = cmd_wr && !is_rb && (bus_din[7:6] == 2'(i));
    assign freeze_cmd = named && (bus_din[5:4] == FMT_FREEZE);
    assign rb_pick    = cmd_wr && is_rb && bus_din[i+1];
    assign cw_vec[i]  = named && (bus_din[5:4] != FMT_FREEZE);
    assign lat_cnt[i] = freeze_cmd || (rb_pick && !bus_din[5]);
    assign lat_st[i]  = rb_pick && !bus_din[4];
    assign cnt_wr[i]  = wr_done && (bus_addr == 2'(i));
    assign rd_vec[i]  = rd_done && (bus_addr == 2'(i));

    tmr_chan_regs #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cw_wr    (cw_vec[i]),
      .cw_bits  (bus_din[CTL_W-1:0]),
      .cnt_wr   (cnt_wr[i]),
      .wr_data  (bus_din),
      .lat_cnt  (lat_cnt[i]),
      .lat_st   (lat_st[i]),
      .rd_done  (rd_vec[i]),
      .live_cnt (ch_count[i]),
      .out_lvl  (ch_out[i]),
      .load     (ch_load[i]),
      .rd_byte  (rd_bytes[i]),
      .cr       (ch_cr[i]),
      .mode     (ch_mode[i]),
      .null_cnt (ch_null[i]),
      .cr_wr    (ch_cr_wr[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    rd_hit = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == 2'(i)) begin
        rd_sel = rd_bytes[i];
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout <= '0;
      ch_cw_wr <= '0;
    end else begin
      bus_dout <= (!bus_cs_n && !bus_rd_n && rd_hit) ? rd_sel : '0;
      ch_cw_wr <= cw_vec;
    end
  end

  // R12: read data stays idle unless a read strobe was low at the previous edge
  assert_dout_idle_R12: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd_n) |-> (bus_dout == '0));

  // R2: a command byte reprograms at most one channel
  assert_single_cw_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_cw_wr));
endmodule

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [1:0] bus_addr = 2'b00;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic [2:0][15:0] ch_count = '0;
  logic [2:0] ch_out = '0, ch_load = '0;
  logic [2:0][15:0] ch_cr;
  logic [2:0][5:0] ch_mode;
  logic [2:0] ch_null, ch_cr_wr, ch_cw_wr;

  int checks = 0, fails = 0;
  int crw_cnt [3];
  int cww_cnt [3];
  logic [7:0] rb;

  always #5 clk = ~clk;

  tmr_host_if uut (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .ch_count(ch_count), .ch_out(ch_out),
    .ch_load(ch_load), .ch_cr(ch_cr), .ch_mode(ch_mode), .ch_null(ch_null),
    .ch_cr_wr(ch_cr_wr), .ch_cw_wr(ch_cw_wr)
  );

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (rst) begin
        crw_cnt[i] <= 0;
        cww_cnt[i] <= 0;
      end else begin
        crw_cnt[i] <= crw_cnt[i] + int'(ch_cr_wr[i]);
        cww_cnt[i] <= cww_cnt[i] + int'(ch_cw_wr[i]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_cs_n = 1'b0; bus_addr = a; bus_din = d; bus_wr_n = 1'b0;
    @(negedge clk); bus_wr_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_nocs(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_din = d; bus_wr_n = 1'b0;
    @(negedge clk); bus_wr_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_cs_n = 1'b0; bus_addr = a; bus_rd_n = 1'b0;
    @(negedge clk);
    @(negedge clk); d = bus_dout; bus_rd_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_load(input int c);
    @(negedge clk); ch_load[c] = 1'b1;
    @(negedge clk); ch_load[c] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, exp;
    logic [7:0] cw, sx;
    int n0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    for (int c = 0; c < 3; c++) begin
      chk(ch_cr[c] == 16'h0 && ch_mode[c] == 6'h30 && ch_null[c] == 1'b0,
          "R13 reset state", {ch_cr[c][7:0], 1'b0, ch_null[c], ch_mode[c]}, 16'h0030);
    end
    chk(bus_dout == 8'h00, "R12 idle dout after reset", {8'h0, bus_dout}, 16'h0);

    // Sweep: every channel, every format, every mode
    for (int c = 0; c < 3; c++) begin
      for (int f = 1; f < 4; f++) begin
        for (int m = 0; m < 6; m++) begin
          cw = {2'(c), 2'(f), 3'(m), 1'(m ^ f)};
          v  = 16'((c + 1) * 4099 + f * 257 + m * 17);
          n0 = cww_cnt[c];
          wr(2'b11, cw);
          chk(ch_mode[c] == cw[5:0], "R2 mode field", {10'h0, ch_mode[c]}, {10'h0, cw[5:0]});
          chk(cww_cnt[c] == n0 + 1, "R2 reprogram pulse", 16'(cww_cnt[c]), 16'(n0 + 1));
          chk(ch_cr[c] == 16'h0 && ch_null[c], "R3 count cleared, R10 null set", ch_cr[c], 16'h0);
          n0 = crw_cnt[c];
          if (f == 1) begin
            wr(2'(c), v[7:0]); exp = {8'h00, v[7:0]};
          end else if (f == 2) begin
            wr(2'(c), v[15:8]); exp = {v[15:8], 8'h00};
          end else begin
            wr(2'(c), v[7:0]);
            chk(ch_cr[c] == {8'h00, v[7:0]} && crw_cnt[c] == n0,
                "R4 first byte to low half, no pulse", ch_cr[c], {8'h00, v[7:0]});
            wr(2'(c), v[15:8]); exp = v;
          end
          chk(ch_cr[c] == exp, "R3/R4 byte steering", ch_cr[c], exp);
          chk(crw_cnt[c] == n0 + 1, "R4 one pulse per count", 16'(crw_cnt[c]), 16'(n0 + 1));
          ch_out[c] = 1'(m);
          rb = 8'hE0 | 8'(1 << (c + 1));
          wr(2'b11, rb);
          rd(2'(c), sx);
          chk(sx == {1'(m), 1'b1, cw[5:0]}, "R7/R8 status read-back", {8'h0, sx}, {8'h0, 1'(m), 1'b1, cw[5:0]});
          pulse_load(c);
          chk(ch_null[c] == 1'b0, "R10 null cleared by load", {15'h0, ch_null[c]}, 16'h0);
        end
      end
    end

    // R5 / R6 count freeze on channel 1
    wr(2'b11, 8'h70);
    ch_count[1] = 16'hA5C3;
    wr(2'b11, 8'h40);
    ch_count[1] = 16'h1234;
    wr(2'b11, 8'h40);
    rd(2'b01, sx); chk(sx == 8'hC3, "R5/R6 frozen low byte", {8'h0, sx}, 16'h00C3);
    rd(2'b01, sx); chk(sx == 8'hA5, "R5 frozen high byte", {8'h0, sx}, 16'h00A5);
    rd(2'b01, sx); chk(sx == 8'h34, "R5 released to live low", {8'h0, sx}, 16'h0034);
    rd(2'b01, sx); chk(sx == 8'h12, "R5 live high", {8'h0, sx}, 16'h0012);
    wr(2'b11, 8'h40);
    ch_count[1] = 16'h5678;
    wr(2'b11, 8'h70);
    rd(2'b01, sx); chk(sx == 8'h78, "R5 reprogram releases freeze", {8'h0, sx}, 16'h0078);
    rd(2'b01, sx);

    // R9 status before count, both latch orders, channel 2
    wr(2'b11, 8'hB6);
    ch_out[2] = 1'b1;
    ch_count[2] = 16'h0F0E;
    wr(2'b11, 8'hC8);
    ch_count[2] = 16'h7777;
    rd(2'b10, sx); chk(sx == 8'hF6, "R9 status first", {8'h0, sx}, 16'h00F6);
    rd(2'b10, sx); chk(sx == 8'h0E, "R9 frozen low", {8'h0, sx}, 16'h000E);
    rd(2'b10, sx); chk(sx == 8'h0F, "R9 frozen high", {8'h0, sx}, 16'h000F);
    rd(2'b10, sx); chk(sx == 8'h77, "R9 then live", {8'h0, sx}, 16'h0077);
    rd(2'b10, sx);
    ch_count[2] = 16'h2B1A;
    wr(2'b11, 8'hD8);
    ch_out[2] = 1'b0;
    wr(2'b11, 8'hE8);
    ch_out[2] = 1'b1;
    wr(2'b11, 8'hE8);
    rd(2'b10, sx); chk(sx == 8'h76, "R9 status first when count latched earlier, R6 first status kept", {8'h0, sx}, 16'h0076);
    rd(2'b10, sx); chk(sx == 8'h1A, "R9 count after status", {8'h0, sx}, 16'h001A);
    rd(2'b10, sx);

    // R7 multi-channel count read-back on channels 0 and 1
    wr(2'b11, 8'h30);
    ch_count[0] = 16'hCAFE;
    ch_count[1] = 16'hD00D;
    wr(2'b11, 8'hD6);
    ch_count[0] = 16'h0000;
    ch_count[1] = 16'h0000;
    rd(2'b00, sx); chk(sx == 8'hFE, "R7 ch0 frozen", {8'h0, sx}, 16'h00FE);
    rd(2'b00, sx);
    rd(2'b01, sx); chk(sx == 8'h0D, "R7 ch1 frozen", {8'h0, sx}, 16'h000D);
    rd(2'b01, sx); chk(sx == 8'hD0, "R7 ch1 frozen high", {8'h0, sx}, 16'h00D0);

    // R11 interleaved pointers on channel 0
    wr(2'b11, 8'h30);
    ch_count[0] = 16'hBEEF;
    rd(2'b00, sx); chk(sx == 8'hEF, "R11 read low", {8'h0, sx}, 16'h00EF);
    wr(2'b00, 8'h11);
    rd(2'b00, sx); chk(sx == 8'hBE, "R11 read high after write", {8'h0, sx}, 16'h00BE);
    wr(2'b00, 8'h22);
    chk(ch_cr[0] == 16'h2211, "R11 interleaved write", ch_cr[0], 16'h2211);
    wr(2'b00, 8'h55);
    wr(2'b11, 8'h30);
    wr(2'b00, 8'h33);
    wr(2'b00, 8'h44);
    chk(ch_cr[0] == 16'h4433, "R11 write pointer reset", ch_cr[0], 16'h4433);
    rd(2'b00, sx);
    wr(2'b11, 8'h30);
    rd(2'b00, sx); chk(sx == 8'hEF, "R11 read pointer reset", {8'h0, sx}, 16'h00EF);
    rd(2'b00, sx);

    // R12 command address reads are empty and harmless
    ch_count[1] = 16'h4321;
    wr(2'b11, 8'h40);
    ch_count[1] = 16'h0000;
    rd(2'b11, sx); chk(sx == 8'h00, "R12 command address reads zero", {8'h0, sx}, 16'h0);
    rd(2'b01, sx); chk(sx == 8'h21, "R12 no side effect on freeze", {8'h0, sx}, 16'h0021);
    rd(2'b01, sx);

    // R1 chip select and strobe edge
    wr(2'b00, 8'h66);
    wr(2'b00, 8'h77);
    pulse_load(0);
    wr_nocs(2'b00, 8'h99);
    wr_nocs(2'b00, 8'h88);
    chk(ch_cr[0] == 16'h7766, "R1 write ignored without select", ch_cr[0], 16'h7766);
    wr_nocs(2'b11, 8'h30);
    chk(ch_null[0] == 1'b0, "R1 command ignored without select", {15'h0, ch_null[0]}, 16'h0);
    @(negedge clk); bus_cs_n = 1'b0; bus_addr = 2'b00; bus_din = 8'hAB; bus_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ch_cr[0] == 16'h7766, "R1 no effect while strobe low", ch_cr[0], 16'h7766);
    bus_wr_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1;
    chk(ch_cr[0][7:0] == 8'hAB, "R1 effect on strobe rise", ch_cr[0], 16'h77AB);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule